// File: doc/BRIEF.md
# Two-Port Register File With Bypass

This block is a 32-entry register file with one write port and two read ports. The read ports are combinational: each returns an entry in the same cycle its index is presented. A write with its enable high is stored on the rising clock edge. Entry zero is hard-wired to read as zero, and every write aimed at it is discarded.

An elaboration parameter sets how a read and a write in the same cycle are ordered. In read-first order, both ports see the contents as they were before the edge, so a write shows up one cycle later. In write-first order, a read port whose index matches an enabled write to a non-zero entry returns the incoming write data at once. The write is still stored at the edge. This suits a pipeline whose operand reads share a cycle with an older instruction's write-back. The data width is a parameter, and all entries clear to zero on reset.

Top module: `regfile_2r1w`

## Requirements
- R1: After an active-low reset, every entry reads as zero on both read ports.
- R2: An enabled write to a non-zero index stores the write data, and both read ports return it from the next cycle on.
- R3: A write to index 0 never changes entry 0, which always reads as zero.
- R4: In read-first order (ORDER = RF_READ_FIRST), a read that shares a cycle with a write to the same index returns the value held before that write.
- R5: In write-first order (ORDER = RF_WRITE_FIRST), a read port whose index equals the index of an enabled write returns the write data in that same cycle.
- R6: In write-first order, a read port whose index differs from the write index returns the stored entry.
- R7: In write-first order, the forwarded value is also stored and stays readable in later cycles.
- R8: In write-first order, a write to index 0 is not forwarded, so a same-cycle read of index 0 returns zero.
- R9: With the write enable low, no entry changes and nothing is forwarded, whatever the write index and data are.
- R10: The two read ports work independently. They may read the same entry or different entries in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all entries |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Entry written |
| wr_data | input | DATA_W | Value written |
| rd_a_idx | input | 5 | Entry read on port A |
| rd_a_data | output | DATA_W | Port A result |
| rd_b_idx | input | 5 | Entry read on port B |
| rd_b_data | output | DATA_W | Port B result |

## Verification
The assertions assume that the write controls and read indices are known (never X) at each rising edge while reset is released, and that they stay steady around that edge. The bench drives every input on the falling edge from a complete vector table, holds each value for a full cycle, and sets all inputs to defined values from time zero. Both orderings are checked side by side, with the same stimulus fed to one instance of each. The write-first instance therefore sees the same collisions that the read-first instance must not forward.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // Ordering of a same-cycle read against the write port.
    typedef enum logic {
        RF_READ_FIRST  = 1'b0,
        RF_WRITE_FIRST = 1'b1
    } rf_order_e;

    // Number of read ports of the register file.
    localparam int RF_NUM_RD = 2;

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
    parameter int DEPTH = 32,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    output logic [DEPTH-1:0] ent_we
);

    // Entry 0 gets no strobe at all; the rest match the index.
    for (genvar g = 0; g < DEPTH; g++) begin : g_strobe
        if (g == 0) begin : g_zero
            assign ent_we[g] = 1'b0;
        end else begin : g_live
            assign ent_we[g] = wr_en && (wr_idx == IDX_W'(g));
        end
    end

    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ent_we));

    assert_idle_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (ent_we == '0));

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DEPTH-1:0]             ent_we,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [DEPTH-1:0][DATA_W-1:0] ent_q
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] ent;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_we[i]) begin
                st_d.ent[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ent_q = st_q.ent;

    assert_entry0_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ent[0] == '0);

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_we == '0) |=> $stable(st_q));

    for (genvar g = 1; g < DEPTH; g++) begin : g_chk
        assert_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ent_we[g] |=> (st_q.ent[g] == $past(wr_data)));
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
#(
    parameter int        DEPTH  = 32,
    parameter int        DATA_W = 32,
    parameter int        IDX_W  = $clog2(DEPTH),
    parameter rf_order_e ORDER  = RF_READ_FIRST
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DEPTH-1:0][DATA_W-1:0] ent_q,
    input  logic [IDX_W-1:0]             rd_idx,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [DATA_W-1:0]            rd_data
);

    logic [DATA_W-1:0] stored;

    always_comb begin
        stored = ent_q[rd_idx];
    end

    if (ORDER == RF_WRITE_FIRST) begin : g_fwd
        logic hit;

        always_comb begin
            hit     = wr_en && (wr_idx == rd_idx) && (wr_idx != '0);
            rd_data = hit ? wr_data : stored;
        end

        assert_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_idx == rd_idx) && (rd_idx != '0)) |-> (rd_data == wr_data));

        assert_zero_not_forwarded_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_idx == '0) |-> (rd_data == '0));

    end else begin : g_plain
        always_comb begin
            rd_data = stored;
        end

        assert_no_early_view_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_idx == rd_idx) && (wr_data != stored))
            |-> (rd_data != wr_data));

        assert_zero_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_idx == '0) |-> (rd_data == '0));
    end

endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w
    import rf_pkg::*;
#(
    parameter int        DATA_W = 32,
    parameter int        DEPTH  = 32,
    parameter rf_order_e ORDER  = RF_READ_FIRST,
    localparam int       IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data
);

    logic [DEPTH-1:0]             ent_we;
    logic [DEPTH-1:0][DATA_W-1:0] ent_q;
    logic [IDX_W-1:0]             rd_idx_v  [RF_NUM_RD];
    logic [DATA_W-1:0]            rd_data_v [RF_NUM_RD];

    always_comb begin
        rd_idx_v[0] = rd_a_idx;
        rd_idx_v[1] = rd_b_idx;
    end

    assign rd_a_data = rd_data_v[0];
    assign rd_b_data = rd_data_v[1];

    rf_wr_decode #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) i_rf_wr_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .ent_we (ent_we)
    );

    rf_storage #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) i_rf_storage (
        .clk     (clk),
        .rst_n   (rst_n),
        .ent_we  (ent_we),
        .wr_data (wr_data),
        .ent_q   (ent_q)
    );

    for (genvar p = 0; p < RF_NUM_RD; p++) begin : g_rd
        rf_read_port #(
            .DEPTH  (DEPTH),
            .DATA_W (DATA_W),
            .IDX_W  (IDX_W),
            .ORDER  (ORDER)
        ) i_rf_read_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .ent_q   (ent_q),
            .rd_idx  (rd_idx_v[p]),
            .wr_en   (wr_en),
            .wr_idx  (wr_idx),
            .wr_data (wr_data),
            .rd_data (rd_data_v[p])
        );
    end

    // Both ports on one index must agree (independence without interference).
    assert_ports_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));

endmodule

// File: tb/test_regfile_2r1w.sv
module test_regfile_2r1w;
    import rf_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_a_idx = '0;
    logic [4:0]  rd_b_idx = '0;
    logic [31:0] n_a, n_b, f_a, f_b;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    regfile_2r1w #(.DATA_W(32), .ORDER(RF_READ_FIRST)) i_regfile_2r1w (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_a_idx(rd_a_idx), .rd_a_data(n_a), .rd_b_idx(rd_b_idx), .rd_b_data(n_b)
    );

    regfile_2r1w #(.DATA_W(32), .ORDER(RF_WRITE_FIRST)) i_regfile_2r1w_fwd (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_a_idx(rd_a_idx), .rd_a_data(f_a), .rd_b_idx(rd_b_idx), .rd_b_data(f_b)
    );

    typedef struct packed {
        logic        we;
        logic [4:0]  wi;
        logic [31:0] wd;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [31:0] na;
        logic [31:0] nb;
        logic [31:0] fa;
        logic [31:0] fb;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd5,  32'hA5A5_0001, 5'd5,  5'd6, 32'h0,          32'h0,          32'hA5A5_0001, 32'h0},
        '{1'b1, 5'd6,  32'h0000_BEEF, 5'd5,  5'd6, 32'hA5A5_0001, 32'h0,          32'hA5A5_0001, 32'h0000_BEEF},
        '{1'b1, 5'd0,  32'hFFFF_FFFF, 5'd0,  5'd5, 32'h0,          32'hA5A5_0001, 32'h0,          32'hA5A5_0001},
        '{1'b0, 5'd5,  32'h1234_5678, 5'd5,  5'd5, 32'hA5A5_0001, 32'hA5A5_0001, 32'hA5A5_0001, 32'hA5A5_0001},
        '{1'b1, 5'd31, 32'h8000_0000, 5'd31, 5'd31, 32'h0,         32'h0,          32'h8000_0000, 32'h8000_0000},
        '{1'b1, 5'd5,  32'h0000_0077, 5'd31, 5'd0, 32'h8000_0000, 32'h0,          32'h8000_0000, 32'h0},
        '{1'b0, 5'd0,  32'h0,         5'd5,  5'd6, 32'h0000_0077, 32'h0000_BEEF, 32'h0000_0077, 32'h0000_BEEF},
        '{1'b1, 5'd6,  32'hCAFE_0006, 5'd6,  5'd5, 32'h0000_BEEF, 32'h0000_0077, 32'hCAFE_0006, 32'h0000_0077},
        '{1'b0, 5'd6,  32'h0,         5'd6,  5'd0, 32'hCAFE_0006, 32'h0,          32'hCAFE_0006, 32'h0}
    };

    function automatic string vec_tag(int k);
        case (k)
            0: return "R4 R5 R6";
            1: return "R2 R5 R10";
            2: return "R3 R8";
            3: return "R9";
            4: return "R4 R5 R10";
            5: return "R2 R6";
            6: return "R7 R2";
            7: return "R4 R5 R6";
            8: return "R7 R9";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(logic we, logic [4:0] wi, logic [31:0] wd, logic [4:0] ra, logic [4:0] rb);
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_data = wd; rd_a_idx = ra; rd_b_idx = rb;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, swept over every index on both ports
        for (int i = 0; i < 32; i++) begin
            drive(1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i));
            chk("R1 norm A", n_a, 32'h0);
            chk("R1 fwd B", f_b, 32'h0);
        end

        // Main vector table
        for (int k = 0; k < NV; k++) begin
            drive(VECS[k].we, VECS[k].wi, VECS[k].wd, VECS[k].ra, VECS[k].rb);
            chk({vec_tag(k), " norm A"}, n_a, VECS[k].na);
            chk({vec_tag(k), " norm B"}, n_b, VECS[k].nb);
            chk({vec_tag(k), " fwd A"},  f_a, VECS[k].fa);
            chk({vec_tag(k), " fwd B"},  f_b, VECS[k].fb);
        end

        // R9: disabled write to a live entry leaves it untouched next cycle
        drive(1'b0, 5'd31, 32'hDEAD_DEAD, 5'd31, 5'd31);
        drive(1'b0, 5'd0, 32'h0, 5'd31, 5'd0);
        chk("R9 norm hold", n_a, 32'h8000_0000);
        chk("R9 fwd hold", f_a, 32'h8000_0000);

        // R3: entry 0 still zero after the earlier write attempt
        chk("R3 norm entry0", n_b, 32'h0);
        chk("R3 fwd entry0", f_b, 32'h0);

        // R1: reset in the middle of operation clears written entries
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 5'd0, 32'h0, 5'd5, 5'd6);
        chk("R1 norm after rerun A", n_a, 32'h0);
        chk("R1 fwd after rerun B", f_b, 32'h0);
        drive(1'b0, 5'd0, 32'h0, 5'd31, 5'd31);
        chk("R1 fwd after rerun A", f_a, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule